// File: doc/BRIEF.md
# Two-Group Key Pad Input Port

This block is a single byte-wide I/O location through which a processor reads an eight-key pad. The keys are wired as two groups of four. Software writes two active-low select bits into the upper half of the location. Reads return that upper half unchanged. The lower half of a read shows the chosen key group, inverted, so that a pressed key reads as 0.

Group A is the upper four key inputs and is chosen by select bit 5. Group B is the lower four key inputs and is chosen by select bit 6. When both select bits are low, bit 5 wins. When neither select bit is low, the lower half reads as all ones. The read path has no registers, so the value on the bus follows the key inputs in the same cycle.

The port answers only at its one address. At every other address it drives zero onto the read data, so it can be OR-ed onto a shared read bus.

Top module: `keypad_port`

## Requirements
- R1: After reset the stored upper nibble is 0xF, so a read of the port returns 0xFF whatever the key inputs are.
- R2: The port decodes only address 0xFF00. At any other address `rd_hit` is 0, `rd_data` is 0x00, and writes leave the stored nibble unchanged.
- R3: A write with `bus_we` high at 0xFF00 stores `bus_wdata[7:4]` on the next rising clock edge. `bus_wdata[3:0]` is discarded.
- R4: When stored bit 5 is 0, read bits 3:0 equal the inverse of `key_pressed[7:4]`.
- R5: When stored bit 5 is 1 and stored bit 6 is 0, read bits 3:0 equal the inverse of `key_pressed[3:0]`.
- R6: When stored bits 5 and 6 are both 0, group A (`key_pressed[7:4]`) is shown, as in R4.
- R7: When stored bits 5 and 6 are both 1, read bits 3:0 are 0xF for any key inputs.
- R8: Read bits 7:4 always equal the stored nibble.
- R9: A change on `key_pressed` appears on `rd_data` in the same cycle, with no clock edge in between.
- R10: With `bus_we` low, the value on `bus_wdata` at 0xFF00 has no effect on the stored nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released through a synchronizer |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| key_pressed | input | 8 | Debounced key levels, 1 = pressed; [7:4] group A, [3:0] group B |
| rd_data | output | 8 | Read data; 0x00 when the address does not match |
| rd_hit | output | 1 | High when `bus_addr` matches the port address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the port at 0xFF00, an 8-bit data path, and a two-stage reset synchronizer. With these values, every combination of the two select bits can be reached with a single write, so select priority can be checked against the key patterns. Neighbouring addresses such as 0xFF01 can also be used to exercise the decode boundary. Same-cycle key changes are checked without any clock edge, and a second reset in the middle of the run shows that the register returns to its reset value.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NIB_W     = DATA_W / 2;
  // absolute positions of the active-low group selects in the port byte
  localparam int unsigned SEL_A_BIT = 5;
  localparam int unsigned SEL_B_BIT = 6;
  // positions inside the stored upper nibble
  localparam int unsigned SEL_A_REL = SEL_A_BIT - NIB_W;
  localparam int unsigned SEL_B_REL = SEL_B_BIT - NIB_W;

  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/kp_rst_sync.sv
module kp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/kp_addr_match.sv
module kp_addr_match #(
  parameter int unsigned    ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = (addr == PORT_ADDR);
endmodule

// File: rtl/kp_sel_reg.sv
module kp_sel_reg
  import kp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  nib_t wr_nib,
  output nib_t sel_q
);
  nib_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) sel_d = wr_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '1;
    else        sel_q <= sel_d;
  end

  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel_q == $past(wr_nib)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/kp_group_mux.sv
module kp_group_mux
  import kp_pkg::*;
(
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic [DATA_W-1:0] keys,
  output nib_t              nib_out
);
  for (genvar i = 0; i < NIB_W; i++) begin : g_bit
    logic grp_a_bit;
    logic grp_b_bit;
    assign grp_a_bit  = keys[NIB_W + i];
    assign grp_b_bit  = keys[i];
    // group A wins when both selects are low
    assign nib_out[i] = !sel_a_n ? ~grp_a_bit :
                        !sel_b_n ? ~grp_b_bit : 1'b1;
  end
endmodule

// File: rtl/keypad_port.sv
module keypad_port
  import kp_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'hFF00,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] key_pressed,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit
);
  logic rst_sync_n;
  logic hit;
  logic wr_en;
  nib_t sel_q;
  nib_t low_nib;

  kp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  kp_addr_match #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_match (
    .addr(bus_addr),
    .hit (hit)
  );

  assign wr_en = bus_we & hit;

  kp_sel_reg u_sel (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_en),
    .wr_nib(bus_wdata[DATA_W-1:NIB_W]),
    .sel_q (sel_q)
  );

  kp_group_mux u_mux (
    .sel_a_n(sel_q[SEL_A_REL]),
    .sel_b_n(sel_q[SEL_B_REL]),
    .keys   (key_pressed),
    .nib_out(low_nib)
  );

  assign rd_hit  = hit;
  assign rd_data = hit ? {sel_q, low_nib} : '0;

  assert_miss_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr != PORT_ADDR) |-> (rd_data == '0));

  assert_grp_a_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hit && !rd_data[SEL_A_BIT]) |-> (rd_data[NIB_W-1:0] == ~key_pressed[DATA_W-1:NIB_W]));

  assert_grp_b_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hit && rd_data[SEL_A_BIT] && !rd_data[SEL_B_BIT])
      |-> (rd_data[NIB_W-1:0] == ~key_pressed[NIB_W-1:0]));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hit && rd_data[SEL_A_BIT] && rd_data[SEL_B_BIT]) |-> (&rd_data[NIB_W-1:0]));

  assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hit && $past(rd_hit) && !$past(bus_we)) |-> $stable(rd_data[DATA_W-1:NIB_W]));
endmodule

// File: tb/keypad_port_tb.sv
module keypad_port_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  key_pressed;
  logic [7:0]  rd_data;
  logic        rd_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  keypad_port u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .key_pressed(key_pressed),
    .rd_data    (rd_data),
    .rd_hit     (rd_hit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write data, key inputs, expected read at 0xFF00}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    24'hD0_A5_D5,  // R4 bit5 low, group A
    24'hD7_3C_DC,  // R4, R3 low write bits dropped
    24'hB0_3C_B3,  // R5 bit6 low, group B
    24'hA0_81_AE,  // R5
    24'h90_5A_9A,  // R6 both low, A wins
    24'h00_F0_00,  // R6
    24'hF0_FF_FF,  // R7 neither low
    24'h60_00_6F,  // R7
    24'hC0_FF_C0,  // R4 all pressed
    24'h50_0F_5F   // R4 none of A pressed
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = we;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_addr  = 16'hFF00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    bus_addr    = 16'hFF00;
    bus_wdata   = 8'h00;
    bus_we      = 1'b0;
    key_pressed = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset value, keys ignored
    #1 check("R1", rd_data, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      key_pressed = VEC[i][15:8];
      bus_write(16'hFF00, VEC[i][23:16], 1'b1);
      #1 check("R4-R8 table", rd_data, VEC[i][7:0]);
    end

    // R2 miss address reads zero, no hit
    bus_write(16'hFF00, 8'hD0, 1'b1);
    key_pressed = 8'h00;
    bus_addr = 16'hFF01;
    #1 check("R2 miss data", rd_data, 8'h00);
    check("R2 miss hit", {7'b0, rd_hit}, 8'h00);
    bus_addr = 16'hFEFF;
    #1 check("R2 miss data low", rd_data, 8'h00);
    // R2 write elsewhere ignored
    bus_write(16'hFF01, 8'h00, 1'b1);
    #1 check("R2 stray write", rd_data, 8'hDF);

    // R10 data without strobe ignored
    bus_write(16'hFF00, 8'h20, 1'b0);
    #1 check("R10 no strobe", rd_data, 8'hDF);

    // R9 same-cycle key visibility
    @(negedge clk);
    key_pressed = 8'h80;
    #1 check("R9 key A change", rd_data, 8'hD7);
    key_pressed = 8'hF0;
    #1 check("R9 key A all", rd_data, 8'hD0);

    // R3 low write bits never reach the upper nibble
    bus_write(16'hFF00, 8'hBF, 1'b1);
    key_pressed = 8'h0F;
    #1 check("R3 low bits", rd_data, 8'hB0);

    // R1 reset again from a non-reset value
    do_reset();
    #1 check("R1 second reset", rd_data, 8'hFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule